// File: doc/BRIEF.md
# Level-Gated Pulse Width Timer

This block is a 16-bit down-counter that measures how long an external signal dwells at a chosen level. Software picks high or low as the level to measure, loads a start value through a byte-wide latch, and clears the stop bit. The counter then loses one count per prescaled count pulse, but only while the synchronized input sits at the selected level. Once the pulse has ended, software reads the counter. The measured width, in count pulses, is the start value minus the value read.

Count pulses come from a free-running divider on the main clock, which divides by 16 by default. When the counter is at zero and a count pulse arrives, the counter reloads from the latch and raises an underflow request. The edge that ends a measured pulse raises an edge request. That edge is falling when high time is measured and rising when low time is measured. Each request stays pending until software clears it with a write-one strobe, and it reaches its interrupt output only when its enable bit is set.

Reads take the high byte first. That read also captures the low byte, so the following low-byte read returns the matching half of the same 16-bit value. A read never changes the counter.

Top module: `pulse_width_timer`

## Requirements
- R1: After a synchronous reset the counter, the latch, both request flags, `rd_data`, `irq_edge` and `irq_uflow` are all zero.
- R2: Counting is gated as follows. The counter decrements by exactly 1 on each count pulse, and count pulses occur once every PRESCALE (16) clocks. It counts only when `stop` is 0 and the input, after a 2-flop synchronizer, equals `meas_high` (1 selects high, 0 selects low). An active interval of 16·N clocks therefore removes exactly N counts.
- R3: While `stop` is 1 and no latch write occurs, the counter holds its value whatever the input does.
- R4: A count pulse that finds the counter at 0x0000 copies the latch into the counter and sets the underflow flag.
- R5: `latch_wr_lo` writes `wr_data` into latch bits 7:0, and `latch_wr_hi` writes it into latch bits 15:8. While `stop` is 1, such a write also loads the whole updated latch into the counter. While `stop` is 0, the write changes only the latch.
- R6: With `meas_high`=1 a falling edge of the synchronized input sets the edge flag; with `meas_high`=0 a rising edge sets it. The opposite edge does not set it.
- R7: `irq_edge` and `irq_uflow` are registered copies of flag AND enable. A flag stays pending while its enable is 0, and it appears at the output once the enable is set.
- R8: A 1 on `clr_edge` or `clr_uflow` clears the matching flag. If a set and a clear land in the same cycle, the set wins.
- R9: A `rd_hi` strobe puts counter bits 15:8 on `rd_data` in the next cycle and captures bits 7:0. A later `rd_lo` strobe returns that captured byte, even if the counter has changed since. Reads never alter the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst | input | 1 | Synchronous active-high reset |
| pulse_in | input | 1 | Asynchronous external pulse to be measured |
| meas_high | input | 1 | 1: measure high time (falling edge ends it); 0: measure low time |
| stop | input | 1 | 1 halts counting; writes then also load the counter |
| latch_wr_lo | input | 1 | Write strobe for latch low byte |
| latch_wr_hi | input | 1 | Write strobe for latch high byte |
| wr_data | input | 8 | Byte written into the latch |
| rd_hi | input | 1 | Read strobe for counter high byte (captures low byte) |
| rd_lo | input | 1 | Read strobe for the captured low byte |
| rd_data | output | 8 | Registered read data, valid the cycle after a strobe |
| en_edge | input | 1 | Enable for the edge interrupt |
| en_uflow | input | 1 | Enable for the underflow interrupt |
| clr_edge | input | 1 | Write-one-to-clear for the edge flag |
| clr_uflow | input | 1 | Write-one-to-clear for the underflow flag |
| irq_edge | output | 1 | Edge interrupt request |
| irq_uflow | output | 1 | Underflow interrupt request |

## Verification
A counter that steps wrongly shows up as a wrong value the next time it is read. Stepping by the wrong amount, stepping when the level or the stop bit forbids it, or missing a reload all appear that way, and the read data carries the error one cycle after the read strobe. A flag that sets on the wrong edge, or that fails to hold or clear, appears on its interrupt pin two clocks after the flag register is disturbed. Some errors stay hidden until a specific sequence occurs. A stale or missing low-byte capture appears only when the counter moves between a high-byte read and a low-byte read. A write while running that wrongly loads the counter appears at the next read.

// File: rtl/pwt_pkg.sv
package pwt_pkg;
  localparam int FLAG_EDGE  = 0;
  localparam int FLAG_UFLOW = 1;
  localparam int NUM_FLAGS  = 2;
  typedef logic [NUM_FLAGS-1:0] flag_vec_t;
endpackage

// File: rtl/pwt_sync.sv
// Multi-stage input synchronizer followed by an edge detector.
module pwt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic level,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] sh_q;
  logic              prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q   <= '0;
      prev_q <= 1'b0;
    end else begin
      sh_q   <= {sh_q[STAGES-2:0], din};
      prev_q <= sh_q[STAGES-1];
    end
  end

  assign level = sh_q[STAGES-1];
  assign rise  = level & ~prev_q;
  assign fall  = ~level & prev_q;
endmodule

// File: rtl/pwt_prescale.sv
// Free-running divider: one-cycle tick every DIV clocks.
module pwt_prescale #(
  parameter int DIV = 16
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int PW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] pcnt_q;

  always_ff @(posedge clk) begin
    if (rst)                pcnt_q <= '0;
    else if (pcnt_q == LAST) pcnt_q <= '0;
    else                    pcnt_q <= pcnt_q + 1'b1;
  end

  assign tick = (pcnt_q == LAST);
endmodule

// File: rtl/pwt_readback.sv
// Two-byte read port; the high-byte read captures the low byte.
module pwt_readback #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] value,
  input  logic             rd_hi,
  input  logic             rd_lo,
  output logic [CNT_W/2-1:0] rd_data
);
  localparam int BW = CNT_W / 2;

  logic [BW-1:0] snap_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      snap_q  <= '0;
      rd_data <= '0;
    end else if (rd_hi) begin
      snap_q  <= value[BW-1:0];
      rd_data <= value[CNT_W-1:BW];
    end else if (rd_lo) begin
      rd_data <= snap_q;
    end
  end
endmodule

// File: rtl/pulse_width_timer.sv
module pulse_width_timer
  import pwt_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int PRESCALE    = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               pulse_in,
  input  logic               meas_high,
  input  logic               stop,
  input  logic               latch_wr_lo,
  input  logic               latch_wr_hi,
  input  logic [CNT_W/2-1:0] wr_data,
  input  logic               rd_hi,
  input  logic               rd_lo,
  output logic [CNT_W/2-1:0] rd_data,
  input  logic               en_edge,
  input  logic               en_uflow,
  input  logic               clr_edge,
  input  logic               clr_uflow,
  output logic               irq_edge,
  output logic               irq_uflow
);
  localparam int BW = CNT_W / 2;

  logic             lvl, rise, fall, tick;
  logic [CNT_W-1:0] cnt_q, latch_q, latch_nx;
  logic             wr_any, count_en;
  flag_vec_t        flag_q, flag_set, flag_clr, flag_en;

  pwt_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rst(rst), .din(pulse_in),
    .level(lvl), .rise(rise), .fall(fall)
  );

  pwt_prescale #(.DIV(PRESCALE)) i_pre (
    .clk(clk), .rst(rst), .tick(tick)
  );

  pwt_readback #(.CNT_W(CNT_W)) i_rd (
    .clk(clk), .rst(rst), .value(cnt_q),
    .rd_hi(rd_hi), .rd_lo(rd_lo), .rd_data(rd_data)
  );

  assign wr_any = latch_wr_lo | latch_wr_hi;

  always_comb begin
    latch_nx = latch_q;
    if (latch_wr_lo) latch_nx[BW-1:0]    = wr_data;
    if (latch_wr_hi) latch_nx[CNT_W-1:BW] = wr_data;
  end

  assign count_en = tick & ~stop & (lvl == meas_high);

  always_ff @(posedge clk) begin
    if (rst) begin
      latch_q <= '0;
      cnt_q   <= '0;
    end else begin
      latch_q <= latch_nx;
      if (wr_any && stop)
        cnt_q <= latch_nx;
      else if (count_en)
        cnt_q <= (cnt_q == '0) ? latch_q : cnt_q - 1'b1;
    end
  end

  assign flag_set[FLAG_EDGE]  = meas_high ? fall : rise;
  assign flag_set[FLAG_UFLOW] = count_en & (cnt_q == '0);
  assign flag_clr[FLAG_EDGE]  = clr_edge;
  assign flag_clr[FLAG_UFLOW] = clr_uflow;
  assign flag_en[FLAG_EDGE]   = en_edge;
  assign flag_en[FLAG_UFLOW]  = en_uflow;

  logic [NUM_FLAGS-1:0] irq_q;

  for (genvar gi = 0; gi < NUM_FLAGS; gi++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst) begin
        flag_q[gi] <= 1'b0;
        irq_q[gi]  <= 1'b0;
      end else begin
        flag_q[gi] <= (flag_q[gi] & ~flag_clr[gi]) | flag_set[gi];
        irq_q[gi]  <= flag_q[gi] & flag_en[gi];
      end
    end
  end

  assign irq_edge  = irq_q[FLAG_EDGE];
  assign irq_uflow = irq_q[FLAG_UFLOW];
endmodule

// File: rtl/pwt_checker.sv
module pwt_checker #(
  parameter int CNT_W = 16
) (
  input logic               clk,
  input logic               rst,
  input logic               stop,
  input logic               wr_any,
  input logic               rd_hi,
  input logic               en_edge,
  input logic               flag_edge,
  input logic               flag_uflow,
  input logic               irq_edge,
  input logic [CNT_W-1:0]   cnt,
  input logic [CNT_W/2-1:0] rd_data
);
  localparam int BW = CNT_W / 2;

  // R2: any change of the counter outside a write or reload is a step of one
  p_step_one_r2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(wr_any) && $past(cnt) != '0 && cnt != $past(cnt))
      |-> cnt == $past(cnt) - 1'b1);

  // R3: a stopped counter without writes holds
  p_stop_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(stop) && !$past(wr_any)) |-> cnt == $past(cnt));

  // R4: the underflow flag only rises out of a zero counter
  p_uflow_zero_r4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $rose(flag_uflow)) |-> $past(cnt) == '0);

  // R7: edge interrupt needs a pending flag and the enable one cycle earlier
  p_irq_gate_r7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && irq_edge) |-> $past(en_edge && flag_edge));

  // R9: a high-byte read returns the counter's upper half
  p_rd_hi_r9: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(rd_hi)) |-> rd_data == $past(cnt[CNT_W-1:BW]));
endmodule

bind pulse_width_timer pwt_checker #(.CNT_W(CNT_W)) i_pwt_checker (
  .clk(clk), .rst(rst), .stop(stop), .wr_any(wr_any), .rd_hi(rd_hi),
  .en_edge(en_edge), .flag_edge(flag_q[0]), .flag_uflow(flag_q[1]),
  .irq_edge(irq_edge), .cnt(cnt_q), .rd_data(rd_data)
);

// File: tb/test_pulse_width_timer.sv
`timescale 1ns/1ps
module test_pulse_width_timer;
  localparam int P = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pulse_in = 1'b0, meas_high = 1'b1, stop = 1'b1;
  logic latch_wr_lo = 1'b0, latch_wr_hi = 1'b0;
  logic [7:0] wr_data = '0;
  logic rd_hi = 1'b0, rd_lo = 1'b0;
  logic [7:0] rd_data;
  logic en_edge = 1'b1, en_uflow = 1'b1, clr_edge = 1'b0, clr_uflow = 1'b0;
  logic irq_edge, irq_uflow;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pulse_width_timer i_pulse_width_timer (
    .clk(clk), .rst(rst), .pulse_in(pulse_in), .meas_high(meas_high),
    .stop(stop), .latch_wr_lo(latch_wr_lo), .latch_wr_hi(latch_wr_hi),
    .wr_data(wr_data), .rd_hi(rd_hi), .rd_lo(rd_lo), .rd_data(rd_data),
    .en_edge(en_edge), .en_uflow(en_uflow), .clr_edge(clr_edge),
    .clr_uflow(clr_uflow), .irq_edge(irq_edge), .irq_uflow(irq_uflow)
  );

  typedef struct packed {
    logic        mh;
    logic [15:0] init;
    logic [7:0]  units;
    logic [15:0] expv;
    logic        uf;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{1'b1, 16'h1234, 8'd5, 16'h122F, 1'b0},
    '{1'b0, 16'h0100, 8'd3, 16'h00FD, 1'b0},
    '{1'b1, 16'h0001, 8'd3, 16'h0000, 1'b1},
    '{1'b0, 16'hABCD, 8'd1, 16'hABCC, 1'b0},
    '{1'b1, 16'h0000, 8'd2, 16'h0000, 1'b1},
    '{1'b0, 16'h8000, 8'd7, 16'h7FF9, 1'b0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_latch(input logic [15:0] v);
    wr_data = v[7:0];  latch_wr_lo = 1'b1; cyc(1);
    latch_wr_lo = 1'b0; wr_data = v[15:8]; latch_wr_hi = 1'b1; cyc(1);
    latch_wr_hi = 1'b0; cyc(1);
  endtask

  task automatic read16(output logic [15:0] v);
    rd_hi = 1'b1; cyc(1);
    rd_hi = 1'b0; v[15:8] = rd_data; rd_lo = 1'b1; cyc(1);
    rd_lo = 1'b0; v[7:0] = rd_data;
  endtask

  task automatic clear_flags();
    clr_edge = 1'b1; clr_uflow = 1'b1; cyc(1);
    clr_edge = 1'b0; clr_uflow = 1'b0; cyc(3);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    cyc(3);
    rst = 1'b0;
    cyc(1);
    // R1: reset state
    check("R1 rd_data", rd_data, 0);
    check("R1 irq_edge", irq_edge, 0);
    check("R1 irq_uflow", irq_uflow, 0);
    read16(v);
    check("R1 counter", v, 16'h0000);

    // Vector walk: R2, R4, R5, R6
    foreach (VECS[i]) begin
      stop = 1'b1;
      meas_high = VECS[i].mh;
      pulse_in = ~VECS[i].mh;
      cyc(6);
      clear_flags();
      write_latch(VECS[i].init);
      read16(v);
      check("R5 stopped load", v, VECS[i].init);
      stop = 1'b0; cyc(3);
      pulse_in = VECS[i].mh;
      cyc(P * VECS[i].units);
      pulse_in = ~VECS[i].mh;
      cyc(6);
      stop = 1'b1; cyc(2);
      read16(v);
      check(VECS[i].uf ? "R4 reload value" : "R2 measured count", v, VECS[i].expv);
      check("R6 end edge flag", irq_edge, 1);
      check("R4 underflow flag", irq_uflow, VECS[i].uf);
    end

    // R3: stopped counter holds with active input
    stop = 1'b1; meas_high = 1'b1; pulse_in = 1'b0; cyc(4);
    write_latch(16'h0050);
    pulse_in = 1'b1; cyc(64);
    read16(v);
    check("R3 stop hold", v, 16'h0050);

    // R9: snapshot coherence and non-destructive reads
    pulse_in = 1'b0; cyc(4);
    write_latch(16'h0100);
    rd_hi = 1'b1; cyc(1);
    rd_hi = 1'b0;
    check("R9 high byte", rd_data, 8'h01);
    stop = 1'b0; pulse_in = 1'b1; cyc(P);
    pulse_in = 1'b0; cyc(6);
    rd_lo = 1'b1; cyc(1);
    rd_lo = 1'b0;
    check("R9 captured low byte", rd_data, 8'h00);
    read16(v);
    check("R9 first full read", v, 16'h00FF);
    read16(v);
    check("R9 repeat read unchanged", v, 16'h00FF);

    // R5: write while running touches only the latch; R4 reload uses it
    stop = 1'b1; write_latch(16'h0000);
    stop = 1'b0; write_latch(16'h0007);
    read16(v);
    check("R5 running write no load", v, 16'h0000);
    clear_flags();
    pulse_in = 1'b1; cyc(P);
    pulse_in = 1'b0; cyc(6);
    stop = 1'b1; cyc(2);
    read16(v);
    check("R4 reload from new latch", v, 16'h0007);
    check("R4 underflow irq", irq_uflow, 1);

    // R8: clear underflow; R6 rising edge ignored when measuring high
    clr_uflow = 1'b1; cyc(1); clr_uflow = 1'b0; cyc(3);
    check("R8 uflow cleared", irq_uflow, 0);
    clear_flags();
    pulse_in = 1'b1; cyc(6);
    check("R6 opposite edge ignored", irq_edge, 0);

    // R7: flag pending while disabled, appears when enabled
    en_edge = 1'b0;
    pulse_in = 1'b0; cyc(6);
    check("R7 masked", irq_edge, 0);
    en_edge = 1'b1; cyc(3);
    check("R7 pending shown", irq_edge, 1);
    clr_edge = 1'b1; cyc(1); clr_edge = 1'b0; cyc(3);
    check("R8 edge cleared", irq_edge, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule